// File: doc/BRIEF.md
# Serial-Loaded Mapper Register File

This block sits on the CPU write path of a cartridge address window. It holds four 5-bit configuration registers that software cannot write in parallel: each value goes in one data bit per bus write, and five accepted writes make one value. The fifth write commits the gathered value to the register picked by that write's two address-select bits. The first bit written ends up as the least significant bit.

Two guards sit in front of the shifter. A write with data bit 7 set aborts any partial value and forces two mode bits of the control register on. A write that lands on the CPU cycle right after another write is dropped. This removes the repeated write that some CPU instructions issue on consecutive cycles. The block also records whether bank register A or B was committed most recently, because the bank decoding logic downstream needs that. Bank decoding itself is not part of this block.

Top module: `serial_mapper_regs`

## Requirements
- R1: After reset the outputs are: `ctrl_q` = 0x0C, `bank_a_q` = 0, `bank_b_q` = 0, and `last_is_b` = 0. `prg_q` is 0x10 when parameter `RAM_OFF_AT_RESET` is 1 and 0x00 when it is 0.
- R2: Each accepted write without bit 7 shifts the 5-bit buffer right and puts `wr_data[0]` into buffer bit 4. The fifth such write therefore commits a value whose bit 0 came from the first write.
- R3: On the fifth accepted write, the value goes to the register selected by that write's `addr_sel`: 0 selects control, 1 selects bank A, 2 selects bank B and 3 selects program. The `addr_sel` of the earlier four writes has no effect. After the commit, the buffer and the bit count are cleared.
- R4: The register outputs and `last_is_b` change only on a clock edge on which a write is presented with `wr_en` and `cyc_en` both high.
- R5: An accepted write with `wr_data[7]` = 1 ignores `wr_data[0]` and discards any partial value. It sets bits 3:2 of `ctrl_q`. It leaves the other control bits and the other three registers unchanged.
- R6: A write is taken only on a clock with `cyc_en` = 1 and `wr_en` = 1. Such a write is dropped when fewer than `MIN_GAP` (default 2) `cyc_en` cycles have passed since the previous write. A dropped write still counts as the previous write for the next gap check.
- R7: A commit to bank A clears `last_is_b` and a commit to bank B sets it. Commits to the control or program register leave it unchanged.
- R8: Data bits 6:1 never affect any register. Holding `wr_en` high while `cyc_en` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_en | input | 1 | One pulse per CPU cycle |
| wr_en | input | 1 | CPU write into the register window |
| addr_sel | input | 2 | Address bits selecting the target register |
| wr_data | input | 8 | CPU data bus |
| ctrl_q | output | 5 | Control register |
| bank_a_q | output | 5 | Bank register A |
| bank_b_q | output | 5 | Bank register B |
| prg_q | output | 5 | Program bank register |
| last_is_b | output | 1 | 1 when bank B was committed more recently than bank A |

## Verification
The serial load is run with asymmetric bit patterns sent to each of the four targets, so a reversed bit order or a wrong target shows up as a mismatched value. Some sequences change `addr_sel` partway through, to show that only the fifth write picks the target. Others hold junk in data bits 6:1, or raise `wr_en` with no cycle strobe, to show that those are ignored. The gap filter is driven with runs of back-to-back writes, which tells a filter that tracks only accepted writes apart from one that also counts dropped writes. An abort is sent both in the middle of a partial value and on the cycle right after another write; the second case shows that the abort passes through the gap filter too.

// File: rtl/serial_mapper_regs.sv
module serial_mapper_regs #(
  parameter bit RAM_OFF_AT_RESET = 1'b1,
  parameter int MIN_GAP          = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_en,
  input  logic       wr_en,
  input  logic [1:0] addr_sel,
  input  logic [7:0] wr_data,
  output logic [4:0] ctrl_q,
  output logic [4:0] bank_a_q,
  output logic [4:0] bank_b_q,
  output logic [4:0] prg_q,
  output logic       last_is_b
);
  localparam int VAL_W = 5;
  localparam int CNT_W = $clog2(VAL_W + 1);
  localparam int GAP_W = (MIN_GAP < 2) ? 1 : $clog2(MIN_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_MAX  = '1;
  localparam logic [VAL_W-1:0] MODE_SET = 5'h0C;
  localparam logic [VAL_W-1:0] PRG_INIT = RAM_OFF_AT_RESET ? 5'h10 : 5'h00;

  logic [VAL_W-1:0] sbuf;
  logic [CNT_W-1:0] cnt;
  logic [GAP_W-1:0] gap;

  wire              wr_cyc  = wr_en & cyc_en;
  wire              gap_ok  = 32'(gap) >= MIN_GAP;
  wire              accept  = wr_cyc & gap_ok;
  wire              abort   = accept & wr_data[7];
  wire              shift   = accept & ~wr_data[7];
  wire [VAL_W-1:0]  nxt_buf = {wr_data[0], sbuf[VAL_W-1:1]};
  wire              commit  = shift && (32'(cnt) == VAL_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= GAP_MAX;
    else if (wr_cyc) gap <= GAP_W'(1);
    else if (cyc_en && gap != GAP_MAX) gap <= gap + GAP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sbuf <= '0;
      cnt  <= '0;
    end else if (abort || commit) begin
      sbuf <= '0;
      cnt  <= '0;
    end else if (shift) begin
      sbuf <= nxt_buf;
      cnt  <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= MODE_SET;
      bank_a_q  <= '0;
      bank_b_q  <= '0;
      prg_q     <= PRG_INIT;
      last_is_b <= 1'b0;
    end else if (abort) begin
      ctrl_q <= ctrl_q | MODE_SET;
    end else if (commit) begin
      case (addr_sel)
        2'd0: ctrl_q <= nxt_buf;
        2'd1: begin bank_a_q <= nxt_buf; last_is_b <= 1'b0; end
        2'd2: begin bank_b_q <= nxt_buf; last_is_b <= 1'b1; end
        default: prg_q <= nxt_buf;
      endcase
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) < VAL_W);

  // R4
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cyc |=> $stable({ctrl_q, bank_a_q, bank_b_q, prg_q, last_is_b}));

  // R5
  abort_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (ctrl_q[3:2] == 2'b11) && $stable({bank_a_q, bank_b_q, prg_q, last_is_b}) && (cnt == '0));

  // R6
  gap_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cyc && !gap_ok) |=> $stable({ctrl_q, bank_a_q, bank_b_q, prg_q, last_is_b, cnt, sbuf}));

  // R7
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cyc && (addr_sel[1] == addr_sel[0])) |=> $stable(last_is_b));
endmodule

// File: tb/tb_serial_mapper_regs.sv
module tb_serial_mapper_regs;
  localparam int PERIOD = 10;

  typedef struct packed {
    logic [4:0] c, a, b, p;
    logic       l;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b0, wr_en = 1'b0;
  logic [1:0] addr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [4:0] ctrl_q, bank_a_q, bank_b_q, prg_q;
  logic       last_is_b;
  logic [4:0] c2, a2, b2, p2;
  logic       l2;

  int checks = 0, errors = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  exp_t  m;
  logic [4:0] mbuf;
  int    mcnt = 0, cyc_now = 0, last_wr = -100;

  always #(PERIOD/2) clk = ~clk;

  serial_mapper_regs dut (
    .clk, .rst_n, .cyc_en, .wr_en, .addr_sel, .wr_data,
    .ctrl_q, .bank_a_q, .bank_b_q, .prg_q, .last_is_b);

  serial_mapper_regs #(.RAM_OFF_AT_RESET(1'b0)) dut_alt (
    .clk, .rst_n, .cyc_en(1'b0), .wr_en(1'b0), .addr_sel(2'b00), .wr_data(8'h00),
    .ctrl_q(c2), .bank_a_q(a2), .bank_b_q(b2), .prg_q(p2), .last_is_b(l2));

  task automatic push(string tag);
    exp_q.push_back(m);
    tag_q.push_back(tag);
  endtask

  task automatic model_write(logic [1:0] sel, logic [7:0] d);
    if (cyc_now - last_wr >= 2) begin
      if (d[7]) begin
        mbuf = '0; mcnt = 0; m.c = m.c | 5'h0C;
      end else begin
        mbuf = {d[0], mbuf[4:1]};
        mcnt++;
        if (mcnt == 5) begin
          case (sel)
            2'd0: m.c = mbuf;
            2'd1: begin m.a = mbuf; m.l = 1'b0; end
            2'd2: begin m.b = mbuf; m.l = 1'b1; end
            default: m.p = mbuf;
          endcase
          mbuf = '0; mcnt = 0;
        end
      end
    end
    last_wr = cyc_now;
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d, string tag);
    @(negedge clk);
    cyc_en = 1'b1; wr_en = 1'b1; addr_sel = sel; wr_data = d;
    @(posedge clk);
    model_write(sel, d);
    cyc_now++;
    #1 push(tag);
    @(negedge clk);
    wr_en = 1'b0; cyc_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc_en = 1'b1; wr_en = 1'b0;
      @(posedge clk);
      cyc_now++;
    end
    @(negedge clk);
    cyc_en = 1'b0;
  endtask

  task automatic wr_nostrobe(logic [1:0] sel, logic [7:0] d, string tag);
    @(negedge clk);
    cyc_en = 1'b0; wr_en = 1'b1; addr_sel = sel; wr_data = d;
    @(posedge clk);
    #1 push(tag);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic put5(logic [1:0] sel, logic [4:0] v, logic [7:0] junk, string tag);
    for (int i = 0; i < 5; i++) begin
      wr(sel, (junk & 8'h7E) | {7'd0, v[i]}, tag);
      idle(1);
    end
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      while (exp_q.size() > 0) begin
        exp_t e;
        string t;
        exp_t got;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        got = '{ctrl_q, bank_a_q, bank_b_q, prg_q, last_is_b};
        checks++;
        if (got !== e) begin
          errors++;
          $display("FAIL %s: got c=%h a=%h b=%h p=%h l=%b expected c=%h a=%h b=%h p=%h l=%b",
                   t, got.c, got.a, got.b, got.p, got.l, e.c, e.a, e.b, e.p, e.l);
        end
      end
    end
  end

  initial begin : watchdog
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : driver
    m = '{5'h0C, 5'h00, 5'h00, 5'h10, 1'b0};
    mbuf = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1 push("R1 reset");
    #2;
    checks++;
    if ({c2, a2, b2, p2, l2} !== {5'h0C, 5'h00, 5'h00, 5'h00, 1'b0}) begin
      errors++;
      $display("FAIL R1 variant: got %h expected %h", {c2, a2, b2, p2, l2}, {5'h0C, 15'h0, 5'h00, 1'b0});
    end

    put5(2'd1, 5'b10110, 8'h00, "R2 R3 bank A");
    put5(2'd2, 5'b10011, 8'h00, "R3 R7 bank B");
    put5(2'd3, 5'b01010, 8'h00, "R3 R7 program keeps flag");
    put5(2'd1, 5'b00001, 8'h00, "R7 bank A clears flag");
    put5(2'd2, 5'b11110, 8'h00, "R7 bank B sets flag");
    put5(2'd0, 5'b00011, 8'h00, "R3 R7 control keeps flag");
    wr(2'd0, 8'h81, "R5 abort sets mode bits"); idle(1);

    for (int i = 0; i < 3; i++) begin wr(2'd1, 8'h01, "R5 partial"); idle(1); end
    wr(2'd1, 8'h80, "R5 abort clears partial"); idle(1);
    put5(2'd1, 5'b01001, 8'h00, "R5 fresh value after abort");

    for (int i = 0; i < 4; i++) begin wr(2'd0, {7'd0, i[0]}, "R3 early select ignored"); idle(1); end
    wr(2'd2, 8'h01, "R3 fifth write selects bank B"); idle(1);

    put5(2'd3, 5'b10101, 8'h7E, "R8 junk data bits");

    wr(2'd1, 8'h01, "R6 first write"); wr(2'd1, 8'h01, "R6 second dropped");
    wr(2'd1, 8'h00, "R6 third dropped"); idle(1);
    for (int i = 0; i < 4; i++) begin wr(2'd1, 8'h00, "R6 resume"); idle(1); end

    wr(2'd0, 8'h00, "R6 write"); wr(2'd0, 8'h80, "R6 close abort dropped"); idle(1);
    for (int i = 0; i < 4; i++) begin wr(2'd0, 8'h01, "R6 abort was dropped"); idle(1); end

    for (int i = 0; i < 5; i++) begin
      wr_nostrobe(2'd3, 8'h01, "R8 no strobe ignored");
      wr(2'd3, {7'd0, i[0]}, "R8 strobed writes"); idle(1);
    end

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule